// File: doc/BRIEF.md
# Four-Bit Bit-Slice ALU Datapath

This block is a small microprocessor datapath built from four identical one-bit slices. It has a four-entry register file with two read ports. The value read on port A passes through a one-position shifter. Two operand multiplexers then form R and S. Each slice derives its own propagate and generate terms from R and S under a five-bit one-hot function code. A ripple carry links the slices, and each slice forms its result bit from its propagate term and the incoming carry.

Work proceeds in a two-phase cycle driven from a single clock. In the fetch phase the block captures the register addresses, the external data word, all control inputs and the raw register contents. In the evaluate phase it computes the result from those captured values. On the clock edge that ends evaluation, the result is registered onto the outputs and, if write enable was captured high, it is also written into the register selected by the B address. A controller drives one operation per fetch/evaluate pair and holds its inputs through the fetch edge.

Top module: `bitslice_alu_dp`

## Requirements
- R1: After reset, `f_out`, `c_out`, `sh_out_lo`, `sh_out_hi` and `eval_phase` are 0, and all four registers read back as 0.
- R2: `eval_phase` is 0 in the first cycle after reset and then toggles on every clock edge. A 0 marks a fetch cycle and a 1 marks an evaluate cycle.
- R3: Inputs are sampled only at the edge that ends a fetch cycle, and any change during the evaluate cycle has no effect. The outputs change only at the edge that ends an evaluate cycle.
- R4: `op_ctl` = 5'b00001 (add): `{c_out, f_out}` = R + S + `c_in`.
- R5: `op_ctl` = 5'b00010 (subtract): `{c_out, f_out}` = R + (~S & 4'hF) + `c_in`, which is R − S − 1 + `c_in` with `c_out` as the no-borrow flag.
- R6: `op_ctl` = 5'b00100, 5'b01000 and 5'b10000 give R AND S, R OR S and R XOR S respectively. For these codes `c_out` is 0 and `c_in` has no effect.
- R7: Any `op_ctl` value that is not one of the five codes above gives `f_out` = 0 and `c_out` = 0.
- R8: R is the shifted A-port word when `r_sel` = 0 and `d_in` when `r_sel` = 1. S is the B-port word when `s_zero` = 0 and 0 when `s_zero` = 1.
- R9: `shift_ctl` acts on the A-port word. With 2'b00 or 2'b11 the word passes unchanged. With 2'b01 it moves one place toward the MSB: bit 0 takes `sh_in_lo` and the old MSB appears on `sh_out_hi`. With 2'b10 it moves one place toward the LSB: bit 3 takes `sh_in_hi` and the old bit 0 appears on `sh_out_lo`. A shift-out output that is not used by the current code is 0.
- R10: When `wr_en` is 1, the result is written into the register at `b_addr` at the end of evaluation, and a later fetch reads the new value. When `wr_en` is 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; fetch and evaluate cycles alternate on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_addr | input | 2 | Register read address for port A |
| b_addr | input | 2 | Register read address for port B and the write-back target |
| d_in | input | 4 | External data word, an alternative source for R |
| r_sel | input | 1 | 1 selects `d_in` as R, 0 selects the shifted A word |
| s_zero | input | 1 | 1 forces S to zero, 0 selects the B word |
| op_ctl | input | 5 | One-hot function code |
| shift_ctl | input | 2 | Shift mode applied to the A word |
| sh_in_lo | input | 1 | Fill bit for bit 0 on an upward shift |
| sh_in_hi | input | 1 | Fill bit for bit 3 on a downward shift |
| c_in | input | 1 | Carry into slice 0 for arithmetic codes |
| wr_en | input | 1 | Write the result back into the B register |
| f_out | output | 4 | Registered result |
| c_out | output | 1 | Registered carry out of the top slice |
| sh_out_lo | output | 1 | Registered bit shifted out on a downward shift |
| sh_out_hi | output | 1 | Registered bit shifted out on an upward shift |
| eval_phase | output | 1 | 1 during an evaluate cycle, 0 during a fetch cycle |

## Verification
A phase counter that slips shows at once. The outputs would change on a fetch edge, or a scrambled evaluate-cycle input would leak into the result, and both show in the next sampled result. A wrong register write, such as a wrong address, a missing enable or a write when none was asked for, stays hidden until that register is read again. Read-back operations follow writes closely, so such a fault shows within one or two operations. Faults in the carry chain or in the propagate/generate terms show in the same operation, on `c_out` or in the upper bits of `f_out`, and the bench sweeps every R, S and carry-in combination to reach them.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  localparam logic [4:0] OP_ADD = 5'b00001;
  localparam logic [4:0] OP_SUB = 5'b00010;
  localparam logic [4:0] OP_AND = 5'b00100;
  localparam logic [4:0] OP_OR  = 5'b01000;
  localparam logic [4:0] OP_XOR = 5'b10000;

  localparam logic [1:0] SH_PASS = 2'b00;
  localparam logic [1:0] SH_UP   = 2'b01;
  localparam logic [1:0] SH_DOWN = 2'b10;

  // Returns {propagate, generate} for one slice.
  function automatic logic [1:0] slice_pg(input logic [4:0] op, input logic r, input logic s);
    case (op)
      OP_ADD:  return {r ^ s, r & s};
      OP_SUB:  return {r ^ ~s, r & ~s};
      OP_AND:  return {r & s, 1'b0};
      OP_OR:   return {r | s, 1'b0};
      OP_XOR:  return {r ^ s, 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic op_is_arith(input logic [4:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int WIDTH = 4,
  parameter int NREG  = 4,
  parameter int AW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_a_addr,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data,
  input  logic             wr_stb,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_stb) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] word_in,
  input  logic [1:0]       mode,
  input  logic             fill_lo,
  input  logic             fill_hi,
  output logic [WIDTH-1:0] word_out,
  output logic             spill_lo,
  output logic             spill_hi
);
  always_comb begin
    word_out = word_in;
    spill_lo = 1'b0;
    spill_hi = 1'b0;
    case (mode)
      SH_UP: begin
        word_out = {word_in[WIDTH-2:0], fill_lo};
        spill_hi = word_in[WIDTH-1];
      end
      SH_DOWN: begin
        word_out = {fill_hi, word_in[WIDTH-1:1]};
        spill_lo = word_in[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_dp_pkg::*;
(
  input  logic [4:0] op,
  input  logic       r,
  input  logic       s,
  input  logic       c_in,
  output logic       f,
  output logic       c_out
);
  logic [1:0] pg;

  assign pg    = slice_pg(op, r, s);
  assign c_out = pg[0] | (pg[1] & c_in);
  assign f     = pg[1] ^ c_in;
endmodule

// File: rtl/bitslice_alu_dp.sv
module bitslice_alu_dp
  import alu_dp_pkg::*;
#(
  parameter  int WIDTH = 4,
  parameter  int NREG  = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    a_addr,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] d_in,
  input  logic             r_sel,
  input  logic             s_zero,
  input  logic [4:0]       op_ctl,
  input  logic [1:0]       shift_ctl,
  input  logic             sh_in_lo,
  input  logic             sh_in_hi,
  input  logic             c_in,
  input  logic             wr_en,
  output logic [WIDTH-1:0] f_out,
  output logic             c_out,
  output logic             sh_out_lo,
  output logic             sh_out_hi,
  output logic             eval_phase
);
  // fetch-captured state
  logic [WIDTH-1:0] a_q, b_q, din_q;
  logic [AW-1:0]    wb_addr_q;
  logic [4:0]       op_q;
  logic [1:0]       shift_q;
  logic             rsel_q, szero_q, fill_lo_q, fill_hi_q, cin_q, we_q;

  logic [WIDTH-1:0] rd_a, rd_b, a_shifted, r_opnd, s_opnd, f_comb;
  logic             spill_lo, spill_hi;
  logic [WIDTH:0]   carry;
  logic             fetch_edge, eval_edge, wb_stb;

  assign fetch_edge = !eval_phase;
  assign eval_edge  = eval_phase;
  assign wb_stb     = eval_edge && we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_phase <= 1'b0;
    else        eval_phase <= !eval_phase;
  end

  dp_regfile #(.WIDTH(WIDTH), .NREG(NREG), .AW(AW)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_addr (a_addr),
    .rd_b_addr (b_addr),
    .rd_a_data (rd_a),
    .rd_b_data (rd_b),
    .wr_stb    (wb_stb),
    .wr_addr   (wb_addr_q),
    .wr_data   (f_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q       <= '0;
      b_q       <= '0;
      din_q     <= '0;
      wb_addr_q <= '0;
      op_q      <= '0;
      shift_q   <= SH_PASS;
      rsel_q    <= 1'b0;
      szero_q   <= 1'b0;
      fill_lo_q <= 1'b0;
      fill_hi_q <= 1'b0;
      cin_q     <= 1'b0;
      we_q      <= 1'b0;
    end else if (fetch_edge) begin
      a_q       <= rd_a;
      b_q       <= rd_b;
      din_q     <= d_in;
      wb_addr_q <= b_addr;
      op_q      <= op_ctl;
      shift_q   <= shift_ctl;
      rsel_q    <= r_sel;
      szero_q   <= s_zero;
      fill_lo_q <= sh_in_lo;
      fill_hi_q <= sh_in_hi;
      cin_q     <= c_in;
      we_q      <= wr_en;
    end
  end

  dp_shifter #(.WIDTH(WIDTH)) u_shifter (
    .word_in  (a_q),
    .mode     (shift_q),
    .fill_lo  (fill_lo_q),
    .fill_hi  (fill_hi_q),
    .word_out (a_shifted),
    .spill_lo (spill_lo),
    .spill_hi (spill_hi)
  );

  assign r_opnd   = rsel_q  ? din_q : a_shifted;
  assign s_opnd   = szero_q ? '0    : b_q;
  assign carry[0] = op_is_arith(op_q) ? cin_q : 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .op    (op_q),
      .r     (r_opnd[i]),
      .s     (s_opnd[i]),
      .c_in  (carry[i]),
      .f     (f_comb[i]),
      .c_out (carry[i+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_out     <= '0;
      c_out     <= 1'b0;
      sh_out_lo <= 1'b0;
      sh_out_hi <= 1'b0;
    end else if (eval_edge) begin
      f_out     <= f_comb;
      c_out     <= carry[WIDTH];
      sh_out_lo <= spill_lo;
      sh_out_hi <= spill_hi;
    end
  end
endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_phase,
  input logic [WIDTH-1:0] f_out,
  input logic             c_out,
  input logic             sh_out_lo,
  input logic             sh_out_hi,
  input logic [4:0]       op_q,
  input logic             szero_q,
  input logic [1:0]       shift_q
);
  // R2
  fetch_to_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_phase |=> eval_phase);
  // R2
  eval_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_phase |=> !eval_phase);
  // R3
  quiet_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_phase |=> ($stable(f_out) && $stable(c_out) && $stable(sh_out_lo) && $stable(sh_out_hi)));
  // R6
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_phase && (op_q == OP_AND || op_q == OP_OR || op_q == OP_XOR)) |=> !c_out);
  // R7
  bad_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_phase && $countones(op_q) != 1) |=> (f_out == '0 && !c_out));
  // R8
  s_forced_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_phase && szero_q && op_q == OP_AND) |=> (f_out == '0));
  // R9
  spill_hi_only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_phase && shift_q != SH_UP) |=> !sh_out_hi);
  // R9
  spill_lo_only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_phase && shift_q != SH_DOWN) |=> !sh_out_lo);
endmodule

bind bitslice_alu_dp alu_dp_chk #(.WIDTH(WIDTH)) u_alu_dp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eval_phase (eval_phase),
  .f_out      (f_out),
  .c_out      (c_out),
  .sh_out_lo  (sh_out_lo),
  .sh_out_hi  (sh_out_hi),
  .op_q       (op_q),
  .szero_q    (szero_q),
  .shift_q    (shift_q)
);

// File: tb/test_bitslice_alu_dp.sv
`timescale 1ns/1ps
module test_bitslice_alu_dp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] a_addr = '0, b_addr = '0;
  logic [3:0] d_in = '0;
  logic       r_sel = 1'b0, s_zero = 1'b0;
  logic [4:0] op_ctl = '0;
  logic [1:0] shift_ctl = '0;
  logic       sh_in_lo = 1'b0, sh_in_hi = 1'b0, c_in = 1'b0, wr_en = 1'b0;
  logic [3:0] f_out;
  logic       c_out, sh_out_lo, sh_out_hi, eval_phase;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [3:0] mdl [4];

  bitslice_alu_dp i_bitslice_alu_dp (
    .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .b_addr(b_addr), .d_in(d_in),
    .r_sel(r_sel), .s_zero(s_zero), .op_ctl(op_ctl), .shift_ctl(shift_ctl),
    .sh_in_lo(sh_in_lo), .sh_in_hi(sh_in_hi), .c_in(c_in), .wr_en(wr_en),
    .f_out(f_out), .c_out(c_out), .sh_out_lo(sh_out_lo), .sh_out_hi(sh_out_hi),
    .eval_phase(eval_phase)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One fetch/evaluate pair; starts and ends at a negedge in a fetch cycle.
  task automatic run_op(input string tag, input logic [1:0] aa, input logic [1:0] ba,
                        input logic [3:0] din, input logic rs, input logic sz,
                        input logic [4:0] op, input logic [1:0] sh, input logic lo,
                        input logic hi, input logic ci, input logic we);
    logic [3:0] a, sa, rv, sv, ef;
    logic ec, elo, ehi;
    int sum;
    a = mdl[aa];
    elo = 1'b0; ehi = 1'b0;
    case (sh)
      2'b01: begin sa = ((a << 1) | {3'b000, lo}) & 4'hF; ehi = a[3]; end
      2'b10: begin sa = (a >> 1) | {hi, 3'b000}; elo = a[0]; end
      default: sa = a;
    endcase
    rv = rs ? din : sa;
    sv = sz ? 4'h0 : mdl[ba];
    ec = 1'b0; ef = 4'h0;
    case (op)
      5'b00001: begin sum = int'(rv) + int'(sv) + int'(ci); ef = sum[3:0]; ec = sum[4]; end
      5'b00010: begin sum = int'(rv) + (15 - int'(sv)) + int'(ci); ef = sum[3:0]; ec = sum[4]; end
      5'b00100: ef = rv & sv;
      5'b01000: ef = rv | sv;
      5'b10000: ef = rv ^ sv;
      default: ef = 4'h0;
    endcase
    a_addr = aa; b_addr = ba; d_in = din; r_sel = rs; s_zero = sz; op_ctl = op;
    shift_ctl = sh; sh_in_lo = lo; sh_in_hi = hi; c_in = ci; wr_en = we;
    @(posedge clk);
    @(negedge clk);
    // R3: scramble every input during evaluation
    a_addr = ~aa; b_addr = ~ba; d_in = ~din; r_sel = ~rs; s_zero = ~sz; op_ctl = ~op;
    shift_ctl = ~sh; sh_in_lo = ~lo; sh_in_hi = ~hi; c_in = ~ci; wr_en = ~we;
    @(posedge clk);
    @(negedge clk);
    if (we) mdl[ba] = ef;
    check(tag, {1'b0, sh_out_hi, sh_out_lo, c_out, f_out}, {1'b0, ehi, elo, ec, ef});
  endtask

  task automatic load_reg(input logic [1:0] idx, input logic [3:0] v);
    run_op("R10 write", 2'd0, idx, v, 1'b1, 1'b1, 5'b01000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic read_reg(input string tag, input logic [1:0] idx);
    run_op(tag, idx, 2'd0, 4'h0, 1'b0, 1'b1, 5'b01000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] ops [6];
    string tags [6];
    ops[0] = 5'b00001; tags[0] = "R4 R3";
    ops[1] = 5'b00010; tags[1] = "R5 R3";
    ops[2] = 5'b00100; tags[2] = "R6 and";
    ops[3] = 5'b01000; tags[3] = "R6 or";
    ops[4] = 5'b10000; tags[4] = "R6 xor";
    ops[5] = 5'b00011; tags[5] = "R7";
    for (int i = 0; i < 4; i++) mdl[i] = 4'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 outputs", {4'h0, sh_out_hi, sh_out_lo, c_out, eval_phase}, 8'h00);
    check("R1 result", {4'h0, f_out}, 8'h00);
    // R2 phase toggling
    @(posedge clk); @(negedge clk);
    check("R2 eval", {7'h0, eval_phase}, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R2 fetch", {7'h0, eval_phase}, 8'h00);
    // R1 registers cleared
    for (int k = 0; k < 4; k++) read_reg("R1 regfile", 2'(k));

    // R4 R5 R6 R7: sweep R (via d_in), S (via register 2), carry in
    for (int s = 0; s < 16; s++) begin
      load_reg(2'd2, 4'(s));
      for (int r = 0; r < 16; r++)
        for (int ci = 0; ci < 2; ci++)
          for (int o = 0; o < 6; o++)
            run_op(tags[o], 2'd0, 2'd2, 4'(r), 1'b1, 1'b0, ops[o], 2'b00,
                   1'b0, 1'b0, 1'(ci), 1'b0);
    end

    // R9: every shift code and fill combination on A
    for (int v = 0; v < 16; v++) begin
      load_reg(2'd1, 4'(v));
      for (int sh = 0; sh < 4; sh++)
        for (int fl = 0; fl < 4; fl++)
          run_op("R9 shift", 2'd1, 2'd3, 4'hA, 1'b0, 1'b1, 5'b01000, 2'(sh),
                 fl[0], fl[1], 1'b0, 1'b0);
    end

    // R8: shifted A with B and with zero S, arithmetic
    load_reg(2'd3, 4'h6);
    load_reg(2'd1, 4'hB);
    run_op("R8 a+b", 2'd1, 2'd3, 4'h0, 1'b0, 1'b0, 5'b00001, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op("R8 a+0", 2'd1, 2'd3, 4'h0, 1'b0, 1'b1, 5'b00001, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op("R8 d-b", 2'd1, 2'd3, 4'h2, 1'b1, 1'b0, 5'b00010, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);

    // R10: write-back, no write with enable low, same register on both ports
    run_op("R10 accumulate", 2'd3, 2'd3, 4'h0, 1'b0, 1'b0, 5'b00001, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    read_reg("R10 readback", 2'd3);
    run_op("R10 no write", 2'd1, 2'd3, 4'h0, 1'b0, 1'b0, 5'b10000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) read_reg("R10 regs kept", 2'(k));
    run_op("R10 shifted wb", 2'd1, 2'd0, 4'h0, 1'b0, 1'b1, 5'b01000, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1);
    read_reg("R10 readback0", 2'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule